// File: doc/BRIEF.md
# Half-Bin Fine Timestamp Combiner

This block forms one fine-resolution arrival time for a single discriminated
input pulse. The pulse is timed on two channels of a time-measurement front
end. The second channel sees the pulse half a fine bin late. Each channel
reports a one-cycle strobe together with a 5-bit fine-bin code (0..31). The
code splits the 24 ns reference clock period into 32 bins of 0.750 ns. At each
strobe the block records its own free-running coarse cycle counter. It then
pairs the two channel events of one hit and adds them.

The result is a timestamp in 0.375 ns units, which is half of one fine bin. Its
value is the coarse count of the first channel times 64, plus the two fine
codes. A further 32 is added for every coarse cycle by which the delayed
channel's event trails the first. This extra term covers the case where the
half-bin delay pushes the second channel into the next clock period.

The merged time is given with a one-cycle valid strobe. It stays on the output
register until the next strobe, so downstream logic such as a time-difference
or window compare can sample it at leisure.

Top module: `halfbin_ts_combiner`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `ts_vld` is 0 and `ts` is 0.
- R2: The internal coarse counter is 0 at the first clock edge where reset is low. It rises by one at every later edge and wraps modulo 2^CW. The value recorded for a strobe is the counter value at the edge that samples the strobe.
- R3: When `hit_a` and `hit_b` are high in the same cycle, `ts_vld` is high for exactly the cycle that begins two clock edges after the sampling edge. In that cycle `ts` = cA*64 + `code_a` + `code_b`, where cA is the recorded coarse count.
- R4: When `hit_b` comes L cycles after `hit_a`, with 1 <= L <= MAX_LAG (default 1), the result appears two edges after the `hit_b` sampling edge. Its value is `ts` = cA*64 + `code_a` + `code_b` + 32*L. This is the carry term for a delayed channel that has wrapped into a later coarse cycle.
- R5: When `hit_b` comes more than MAX_LAG cycles after `hit_a`, with no newer `hit_a`, the pending first-channel event is dropped. No `ts_vld` is raised and `ts` is unchanged.
- R6: A `hit_b` with no pending or simultaneous `hit_a` is ignored. No `ts_vld` is raised and `ts` is unchanged.
- R7: A new `hit_a` that comes while an earlier one is still pending replaces it. A later `hit_b` pairs with the newest `hit_a`, and its lag is counted from that `hit_a`.
- R8: `ts_vld` is high for one cycle per completed pair. Between strobes `ts` holds the last merged value.
- R9: `ts` is computed modulo 2^(CW+6). A pair whose delayed channel lands after the coarse counter wraps still gives the wrapped value of the R4 formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_a | input | 1 | Strobe: undelayed channel has a code for a rising edge |
| code_a | input | FW (5) | Fine-bin code of the undelayed channel |
| hit_b | input | 1 | Strobe: half-bin-delayed channel has a code |
| code_b | input | FW (5) | Fine-bin code of the delayed channel |
| ts_vld | output | 1 | One-cycle strobe: new merged timestamp |
| ts | output | CW+FW+1 | Merged timestamp in half-bin units, held between strobes |

## Verification
An ideal front-end model picks a hit phase of 0..63 half-bins inside a known coarse cycle. From that phase it derives both channel codes, and raises the delayed strobe one cycle late for phase 63. The merged value must then equal the cycle count times 64 plus the phase. This separates a correct sum from one that drops the carry or uses only one channel. Directed cases vary the lag between the two strobes (zero, one, and beyond the window), send a lone delayed strobe, and send two first-channel strobes in a row. These tell pairing and replacement apart from stale pairing. A hit placed at the last counter value before wrap, together with long random runs over several counter wraps, shows the modular arithmetic.

// File: rtl/hbts_pkg.sv
package hbts_pkg;
  // Default sizes shared by the block and its bench
  localparam int FINE_W_DEF   = 5;
  localparam int COARSE_W_DEF = 16;
  localparam int MAX_LAG_DEF  = 1;

  // Pairing state of the merge stage
  typedef enum logic [0:0] {
    PAIR_IDLE = 1'b0,
    PAIR_HOLD = 1'b1
  } pair_st_t;
endpackage

// File: rtl/hbts_coarse_cnt.sv
module hbts_coarse_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hbts_chan_cap.sv
module hbts_chan_cap #(
  parameter int CW = 16,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [FW-1:0] code,
  input  logic [CW-1:0] cnt,
  output logic          ev_vld,
  output logic [CW-1:0] ev_cnt,
  output logic [FW-1:0] ev_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_vld  <= 1'b0;
      ev_cnt  <= '0;
      ev_code <= '0;
    end else begin
      ev_vld <= hit;
      if (hit) begin
        ev_cnt  <= cnt;
        ev_code <= code;
      end
    end
  end
endmodule

// File: rtl/hbts_merge.sv
module hbts_merge
  import hbts_pkg::*;
#(
  parameter int CW      = 16,
  parameter int FW      = 5,
  parameter int MAX_LAG = 1,
  localparam int TS_W   = CW + FW + 1,
  localparam int AGE_W  = $clog2(MAX_LAG + 1) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_a_vld,
  input  logic [CW-1:0]   ev_a_cnt,
  input  logic [FW-1:0]   ev_a_code,
  input  logic            ev_b_vld,
  input  logic [CW-1:0]   ev_b_cnt,
  input  logic [FW-1:0]   ev_b_code,
  output logic            pend,
  output logic            out_vld,
  output logic [TS_W-1:0] out_ts
);
  pair_st_t         st_q;
  logic [AGE_W-1:0] age_q;
  logic [CW-1:0]    hold_cnt;
  logic [FW-1:0]    hold_code;

  logic [CW-1:0]    a_cnt;
  logic [FW-1:0]    a_code;
  logic             a_live;
  logic             pair;
  logic [CW-1:0]    lag;
  logic [TS_W-1:0]  sum;

  always_comb begin
    a_cnt  = ev_a_vld ? ev_a_cnt  : hold_cnt;
    a_code = ev_a_vld ? ev_a_code : hold_code;
    a_live = ev_a_vld || (st_q == PAIR_HOLD);
    pair   = ev_b_vld && a_live;
    lag    = ev_b_cnt - a_cnt;
    sum    = {a_cnt, {(FW + 1){1'b0}}}
           + TS_W'(a_code)
           + TS_W'(ev_b_code)
           + (TS_W'(lag) << FW);
  end

  assign pend = (st_q == PAIR_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PAIR_IDLE;
      age_q     <= '0;
      hold_cnt  <= '0;
      hold_code <= '0;
      out_vld   <= 1'b0;
      out_ts    <= '0;
    end else begin
      out_vld <= pair;
      if (pair) out_ts <= sum;
      if (pair) begin
        st_q <= PAIR_IDLE;
      end else if (ev_a_vld) begin
        st_q      <= PAIR_HOLD;
        hold_cnt  <= ev_a_cnt;
        hold_code <= ev_a_code;
        age_q     <= AGE_W'(1);
      end else if (st_q == PAIR_HOLD) begin
        if (age_q >= AGE_W'(MAX_LAG)) st_q <= PAIR_IDLE;
        else                          age_q <= age_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/halfbin_ts_combiner.sv
module halfbin_ts_combiner
  import hbts_pkg::*;
#(
  parameter int CW      = COARSE_W_DEF,
  parameter int FW      = FINE_W_DEF,
  parameter int MAX_LAG = MAX_LAG_DEF,
  localparam int TS_W   = CW + FW + 1,
  localparam int NCH    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit_a,
  input  logic [FW-1:0]   code_a,
  input  logic            hit_b,
  input  logic [FW-1:0]   code_b,
  output logic            ts_vld,
  output logic [TS_W-1:0] ts
);
  logic [CW-1:0] cnt;
  logic          hit_v   [NCH];
  logic [FW-1:0] code_v  [NCH];
  logic          ev_vld  [NCH];
  logic [CW-1:0] ev_cnt  [NCH];
  logic [FW-1:0] ev_code [NCH];
  logic          pend;

  assign hit_v[0]  = hit_a;
  assign hit_v[1]  = hit_b;
  assign code_v[0] = code_a;
  assign code_v[1] = code_b;

  hbts_coarse_cnt #(.CW(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .cnt (cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_cap
    hbts_chan_cap #(.CW(CW), .FW(FW)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit_v[g]),
      .code    (code_v[g]),
      .cnt     (cnt),
      .ev_vld  (ev_vld[g]),
      .ev_cnt  (ev_cnt[g]),
      .ev_code (ev_code[g])
    );
  end

  hbts_merge #(.CW(CW), .FW(FW), .MAX_LAG(MAX_LAG)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .ev_a_vld  (ev_vld[0]),
    .ev_a_cnt  (ev_cnt[0]),
    .ev_a_code (ev_code[0]),
    .ev_b_vld  (ev_vld[1]),
    .ev_b_cnt  (ev_cnt[1]),
    .ev_b_code (ev_code[1]),
    .pend      (pend),
    .out_vld   (ts_vld),
    .out_ts    (ts)
  );
endmodule

// File: rtl/hbts_chk.sv
module hbts_chk #(
  parameter int CW   = 16,
  parameter int TS_W = 22
) (
  input logic            clk,
  input logic            rst,
  input logic [CW-1:0]   cnt,
  input logic            ev_a,
  input logic            ev_b,
  input logic            pend,
  input logic            ts_vld,
  input logic [TS_W-1:0] ts
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == CW'($past(cnt) + 1'b1));

  // R8
  ts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ts_vld |-> $stable(ts));

  // R3
  pair_needs_b_chk: assert property (@(posedge clk) disable iff (rst)
    ts_vld |-> $past(ev_b));

  // R6
  pair_needs_a_chk: assert property (@(posedge clk) disable iff (rst)
    ts_vld |-> $past(ev_a || pend));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ts_vld && ts == '0));
endmodule

bind halfbin_ts_combiner hbts_chk #(.CW(CW), .TS_W(TS_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnt    (cnt),
  .ev_a   (ev_vld[0]),
  .ev_b   (ev_vld[1]),
  .pend   (pend),
  .ts_vld (ts_vld),
  .ts     (ts)
);

// File: tb/test_halfbin_ts_combiner.sv
module test_halfbin_ts_combiner;
  localparam int CW   = 8;
  localparam int FW   = 5;
  localparam int TS_W = CW + FW + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            hit_a = 1'b0, hit_b = 1'b0;
  logic [FW-1:0]   code_a = '0, code_b = '0;
  logic            ts_vld;
  logic [TS_W-1:0] ts;

  int unsigned nedges = 0;
  int checks = 0, fails = 0;
  logic [TS_W-1:0] last_ts = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (!rst) nedges <= nedges + 1;

  halfbin_ts_combiner #(.CW(CW), .FW(FW), .MAX_LAG(1)) i_halfbin_ts_combiner (
    .clk(clk), .rst(rst), .hit_a(hit_a), .code_a(code_a),
    .hit_b(hit_b), .code_b(code_b), .ts_vld(ts_vld), .ts(ts)
  );

  function automatic logic [TS_W-1:0] exp_ts(int unsigned ca, int fa, int fb, int lag);
    return TS_W'(ca * 64 + fa + fb + 32 * lag);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Caller is at a negedge. Drives A now, B after lag cycles, then checks.
  task automatic pair_run(int fa, int fb, int lag, bit expect_out, string req);
    int unsigned ca;
    ca = nedges;
    hit_a = 1'b1; code_a = FW'(fa);
    if (lag == 0) begin hit_b = 1'b1; code_b = FW'(fb); end
    for (int i = 1; i <= lag; i++) begin
      @(negedge clk);
      hit_a = 1'b0;
      if (i == lag) begin hit_b = 1'b1; code_b = FW'(fb); end
    end
    @(negedge clk);
    hit_a = 1'b0; hit_b = 1'b0;
    chk(ts_vld == 1'b0, req, ts_vld, 0);
    @(negedge clk);
    if (expect_out) begin
      chk(ts_vld == 1'b1, req, ts_vld, 1);
      chk(ts == exp_ts(ca, fa, fb, lag), req, ts, exp_ts(ca, fa, fb, lag));
      last_ts = exp_ts(ca, fa, fb, lag);
    end else begin
      chk(ts_vld == 1'b0, req, ts_vld, 0);
      chk(ts == last_ts, req, ts, last_ts);
    end
    @(negedge clk);
    // R8: single-cycle strobe, value held
    chk(ts_vld == 1'b0, "R8", ts_vld, 0);
    chk(ts == last_ts, "R8", ts, last_ts);
  endtask

  // Ideal front end: hit at phase h (half-bins) in the current cycle
  task automatic ideal_hit(int h, string req);
    int fa, fb, lag;
    fa  = h >> 1;
    fb  = ((h + 1) >> 1) & 31;
    lag = (h == 63) ? 1 : 0;
    pair_run(fa, fb, lag, 1'b1, req);
  endtask

  initial begin
    int unsigned seed;
    int unsigned ca;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    chk(ts_vld == 1'b0 && ts == '0, "R1", ts, 0);
    rst = 1'b0;
    // first sampled edge with rst low records coarse 0 (R2)
    ideal_hit(5, "R2");
    chk(ts == TS_W'(5), "R2", ts, 5);

    // R3: same-cycle pairs
    pair_run(0, 0, 0, 1'b1, "R3");
    pair_run(31, 31, 0, 1'b1, "R3");
    // R4: delayed channel one cycle late (carry term)
    pair_run(31, 0, 1, 1'b1, "R4");
    ideal_hit(63, "R4");
    // R5: beyond the window
    pair_run(10, 3, 2, 1'b0, "R5");
    // R6: lone delayed strobe
    hit_b = 1'b1; code_b = 5'd9;
    @(negedge clk); hit_b = 1'b0;
    @(negedge clk); chk(ts_vld == 1'b0, "R6", ts_vld, 0);
    @(negedge clk); chk(ts_vld == 1'b0, "R6", ts_vld, 0);
    chk(ts == last_ts, "R6", ts, last_ts);

    // R7: second A replaces first, B one cycle after second A
    hit_a = 1'b1; code_a = 5'd20;
    @(negedge clk);
    ca = nedges; code_a = 5'd7;
    @(negedge clk);
    hit_a = 1'b0; hit_b = 1'b1; code_b = 5'd4;
    @(negedge clk); hit_b = 1'b0;
    @(negedge clk);
    chk(ts_vld == 1'b1, "R7", ts_vld, 1);
    chk(ts == exp_ts(ca, 7, 4, 1), "R7", ts, exp_ts(ca, 7, 4, 1));
    last_ts = exp_ts(ca, 7, 4, 1);
    @(negedge clk);

    // R9: hit at last counter value before wrap, delayed channel wraps
    while ((nedges & 32'd255) != 32'd255) @(negedge clk);
    ideal_hit(63, "R9");
    chk(ts == TS_W'(255 * 64 + 63), "R9", ts, 255 * 64 + 63);

    // Random ideal hits across several counter wraps (R3 R4 R9)
    for (int n = 0; n < 400; n++) begin
      int gap;
      gap = int'($urandom % 4);
      repeat (gap) @(negedge clk);
      ideal_hit(int'($urandom % 64), "R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule